// File: doc/BRIEF.md
# Serial EEPROM Command Master

This block is the host-side controller for a small three-wire serial EEPROM organised as 64 words of 16 bits. A host presents one command at a time: read, write, erase, write-all, erase-all, write-enable or write-disable, together with a word address and, where needed, a 16-bit data word. The block turns that command into a serial instruction frame. It drives chip select, serial clock and serial data towards the memory, and samples the memory's serial output.

A read returns the addressed word on `rdata` when the one-cycle `done` pulse appears. For commands that program the array, the block closes the frame and keeps chip select low for a minimum time. It then raises chip select again and watches the memory's output line until the memory reports ready. If ready never arrives within a programmable number of cycles, the block pulses `timeout` instead of `done`. The serial clock is a divided version of the system clock. Each half period lasts `SK_HALF` system cycles.

Top module: `seeprom_cmd_master`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done`, `timeout` are low and `rdata` is zero.
- R2: Every frame is sent MSB first as a 1 start bit, a 2-bit opcode and the 6-bit address. The host op code on `cmd_op` is 0=read, 1=write, 2=erase, 3=write-all, 4=erase-all, 5=write-enable, 6=write-disable. Opcode bits are read=10, write=01, erase=11.
- R3: Write-all, erase-all, write-enable and write-disable send opcode 00. The top two address bits are then 01, 10, 11 and 00 respectively, and the lower four address bits are sent as 0.
- R4: Write and write-all frames add the 16 data bits, MSB first, after the address, for 25 clocks in total. Erase, erase-all, write-enable and write-disable frames are 9 clocks long.
- R5: A read adds 16 clocks after the address with `ee_di` low. `ee_do` is sampled on each rising `ee_sk`, MSB first, and the word is on `rdata` when `done` pulses.
- R6: `ee_sk` is high only while `ee_cs` is high, and `ee_di` does not change while `ee_sk` is high or at its rising edge.
- R7: After a write, erase, write-all or erase-all frame, `ee_cs` stays low for at least `CS_LOW_CYC` cycles and is then raised. After `SETTLE_CYC` cycles `ee_do` is polled: high means ready, which ends the command with a `done` pulse and drops `ee_cs`.
- R8: If ready is not seen within `TIMEOUT_CYC` polling cycles, `timeout` pulses for one cycle instead of `done`, `ee_cs` drops and the block returns to idle.
- R9: `busy` rises in the cycle after a command is accepted and stays high until the cycle in which `done` or `timeout` pulses. `cmd_valid` is ignored while `busy` is high, and op code 7 is never accepted.
- R10: Read, write-enable and write-disable end with `done` right after their last clock, without a chip-select low gap or status poll.
- R11: `rdata` changes only while a read frame is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 3 | Host op code (see R2) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Data word for write and write-all |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle pulse when ready never arrived |
| rdata | output | DATA_W | Last word read |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and ready status from the memory |

## Verification
A behavioural memory model in the bench decodes every frame from the serial pins, and each header is compared with the bit pattern computed from the op code and address. A write to each of the 64 addresses with an address-derived pattern, followed by a read of each, separates address bits, data bit order and read sampling. Erase, write-all and erase-all are then told apart by reading back cells they did or did not touch. A model that stays busy past the limit exercises the timeout path. A command offered while busy, and the unused op code, are checked by the frame count and by the memory contents.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

   // Host-side command codes as presented on cmd_op.
   typedef enum logic [2:0] {
      OP_READ  = 3'd0,
      OP_WRITE = 3'd1,
      OP_ERASE = 3'd2,
      OP_WRALL = 3'd3,
      OP_ERALL = 3'd4,
      OP_WREN  = 3'd5,
      OP_WRDIS = 3'd6,
      OP_NONE  = 3'd7
   } host_op_e;

   // Serial opcode field values.
   localparam logic [1:0] SER_READ  = 2'b10;
   localparam logic [1:0] SER_WRITE = 2'b01;
   localparam logic [1:0] SER_ERASE = 2'b11;
   localparam logic [1:0] SER_EXT   = 2'b00;

   // Sub-command selectors carried in the top two address bits.
   localparam logic [1:0] SUB_WRALL = 2'b01;
   localparam logic [1:0] SUB_ERALL = 2'b10;
   localparam logic [1:0] SUB_WREN  = 2'b11;
   localparam logic [1:0] SUB_WRDIS = 2'b00;

endpackage

// File: rtl/seeprom_tick.sv
module seeprom_tick #(
   parameter int HALF = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic tick
);

   initial begin : p_param_chk
      assert (HALF >= 1) else $fatal(1, "HALF must be at least 1");
   end

   generate
      if (HALF == 1) begin : g_every
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign tick = ~clear;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clear || cnt_q == CW'(HALF - 1)) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign tick = ~clear && (cnt_q == CW'(HALF - 1));
      end
   endgenerate

endmodule

// File: rtl/seeprom_frame.sv
module seeprom_frame
   import seeprom_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic [2:0]                   cmd_op,
   input  logic [ADDR_W-1:0]            cmd_addr,
   input  logic [DATA_W-1:0]            cmd_wdata,
   output logic [3+ADDR_W+DATA_W-1:0]   frame,
   output logic [$clog2(3+ADDR_W+DATA_W+1)-1:0] nclk,
   output logic                         is_read,
   output logic                         needs_poll,
   output logic                         legal
);

   localparam int HDR_W   = 3 + ADDR_W;
   localparam int FRAME_W = HDR_W + DATA_W;
   localparam int LW      = $clog2(FRAME_W + 1);

   initial begin : p_param_chk
      assert (ADDR_W >= 3) else $fatal(1, "ADDR_W must be at least 3");
      assert (DATA_W >= 2) else $fatal(1, "DATA_W must be at least 2");
   end

   logic [1:0]        opc;
   logic [ADDR_W-1:0] fld;
   logic              with_data;

   always_comb begin
      opc        = SER_EXT;
      fld        = cmd_addr;
      with_data  = 1'b0;
      is_read    = 1'b0;
      needs_poll = 1'b0;
      legal      = 1'b1;
      case (host_op_e'(cmd_op))
         OP_READ:  begin opc = SER_READ;  is_read = 1'b1; end
         OP_WRITE: begin opc = SER_WRITE; with_data = 1'b1; needs_poll = 1'b1; end
         OP_ERASE: begin opc = SER_ERASE; needs_poll = 1'b1; end
         OP_WRALL: begin
            fld = {SUB_WRALL, {(ADDR_W-2){1'b0}}};
            with_data = 1'b1; needs_poll = 1'b1;
         end
         OP_ERALL: begin
            fld = {SUB_ERALL, {(ADDR_W-2){1'b0}}};
            needs_poll = 1'b1;
         end
         OP_WREN:  fld = {SUB_WREN,  {(ADDR_W-2){1'b0}}};
         OP_WRDIS: fld = {SUB_WRDIS, {(ADDR_W-2){1'b0}}};
         default:  legal = 1'b0;
      endcase
      frame = {1'b1, opc, fld, (with_data ? cmd_wdata : {DATA_W{1'b0}})};
      nclk  = (with_data || is_read) ? LW'(FRAME_W) : LW'(HDR_W);
   end

endmodule

// File: rtl/seeprom_poll.sv
module seeprom_poll #(
   parameter int CS_LOW_CYC  = 60,
   parameter int SETTLE_CYC  = 63,
   parameter int TIMEOUT_CYC = 1250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic ee_do,
   output logic cs_hi,
   output logic ready_q,
   output logic timeout_q,
   output logic active
);

   localparam int M1   = (CS_LOW_CYC > SETTLE_CYC) ? CS_LOW_CYC : SETTLE_CYC;
   localparam int MAXC = (M1 > TIMEOUT_CYC) ? M1 : TIMEOUT_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   initial begin : p_param_chk
      assert (CS_LOW_CYC >= 1)  else $fatal(1, "CS_LOW_CYC must be at least 1");
      assert (SETTLE_CYC >= 1)  else $fatal(1, "SETTLE_CYC must be at least 1");
      assert (TIMEOUT_CYC >= 1) else $fatal(1, "TIMEOUT_CYC must be at least 1");
   end

   typedef enum logic [1:0] {P_IDLE, P_LOW, P_SETTLE, P_WAIT} ph_e;
   ph_e           ph_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= P_IDLE;
         cnt_q     <= '0;
         cs_hi     <= 1'b0;
         ready_q   <= 1'b0;
         timeout_q <= 1'b0;
      end else begin
         ready_q   <= 1'b0;
         timeout_q <= 1'b0;
         case (ph_q)
            P_IDLE: if (start) begin
               ph_q  <= P_LOW;
               cnt_q <= '0;
            end
            P_LOW: if (cnt_q == CW'(CS_LOW_CYC - 1)) begin
               ph_q  <= P_SETTLE;
               cnt_q <= '0;
               cs_hi <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            P_SETTLE: if (cnt_q == CW'(SETTLE_CYC - 1)) begin
               ph_q  <= P_WAIT;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            P_WAIT: if (ee_do) begin
               ready_q <= 1'b1;
               cs_hi   <= 1'b0;
               ph_q    <= P_IDLE;
            end else if (cnt_q == CW'(TIMEOUT_CYC - 1)) begin
               timeout_q <= 1'b1;
               cs_hi     <= 1'b0;
               ph_q      <= P_IDLE;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            default: ph_q <= P_IDLE;
         endcase
      end
   end

   assign active = (ph_q != P_IDLE);

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready_q && timeout_q)); // R8
   AST_TIMEOUT_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_q |-> ($past(ph_q) == P_WAIT)); // R8

endmodule

// File: rtl/seeprom_cmd_master.sv
module seeprom_cmd_master
   import seeprom_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 16,
   parameter int SK_HALF     = 8,
   parameter int CS_LOW_CYC  = 60,
   parameter int SETTLE_CYC  = 63,
   parameter int TIMEOUT_CYC = 1250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              busy,
   output logic              done,
   output logic              timeout,
   output logic [DATA_W-1:0] rdata,
   output logic              ee_cs,
   output logic              ee_sk,
   output logic              ee_di,
   input  logic              ee_do
);

   localparam int HDR_W   = 3 + ADDR_W;
   localparam int FRAME_W = HDR_W + DATA_W;
   localparam int LW      = $clog2(FRAME_W + 1);
   localparam int GW      = $clog2(CS_LOW_CYC + 1);

   typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_POLL} st_e;

   st_e                st_q;
   logic [FRAME_W-1:0] f_frame, shreg_q;
   logic [LW-1:0]      f_len, len_q, bit_q;
   logic               f_read, f_poll, f_legal;
   logic               read_q, pollreq_q;
   logic               sk_q, di_q, scs_q, done_q, to_q;
   logic [DATA_W-1:0]  rd_q;
   logic               tick, accept, last_fall, poll_start;
   logic               poll_cs, poll_rdy, poll_to, poll_act;

   seeprom_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .cmd_op     (cmd_op),
      .cmd_addr   (cmd_addr),
      .cmd_wdata  (cmd_wdata),
      .frame      (f_frame),
      .nclk       (f_len),
      .is_read    (f_read),
      .needs_poll (f_poll),
      .legal      (f_legal)
   );

   seeprom_tick #(.HALF(SK_HALF)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (st_q != S_SHIFT),
      .tick  (tick)
   );

   seeprom_poll #(
      .CS_LOW_CYC  (CS_LOW_CYC),
      .SETTLE_CYC  (SETTLE_CYC),
      .TIMEOUT_CYC (TIMEOUT_CYC)
   ) u_poll (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (poll_start),
      .ee_do     (ee_do),
      .cs_hi     (poll_cs),
      .ready_q   (poll_rdy),
      .timeout_q (poll_to),
      .active    (poll_act)
   );

   assign accept     = cmd_valid && (st_q == S_IDLE) && f_legal;
   assign last_fall  = (st_q == S_SHIFT) && tick && sk_q && (bit_q == len_q - 1'b1);
   assign poll_start = last_fall && pollreq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         shreg_q   <= '0;
         len_q     <= '0;
         bit_q     <= '0;
         read_q    <= 1'b0;
         pollreq_q <= 1'b0;
         sk_q      <= 1'b0;
         di_q      <= 1'b0;
         scs_q     <= 1'b0;
         done_q    <= 1'b0;
         to_q      <= 1'b0;
         rd_q      <= '0;
      end else begin
         done_q <= 1'b0;
         to_q   <= 1'b0;
         case (st_q)
            S_IDLE: if (accept) begin
               st_q      <= S_SHIFT;
               shreg_q   <= f_frame << 1;
               di_q      <= f_frame[FRAME_W-1];
               len_q     <= f_len;
               read_q    <= f_read;
               pollreq_q <= f_poll;
               bit_q     <= '0;
               scs_q     <= 1'b1;
               sk_q      <= 1'b0;
            end
            S_SHIFT: if (tick) begin
               if (!sk_q) begin
                  sk_q <= 1'b1;
                  if (read_q && bit_q >= LW'(HDR_W)) begin
                     rd_q <= {rd_q[DATA_W-2:0], ee_do};
                  end
               end else begin
                  sk_q <= 1'b0;
                  if (bit_q == len_q - 1'b1) begin
                     scs_q <= 1'b0;
                     di_q  <= 1'b0;
                     if (pollreq_q) begin
                        st_q <= S_POLL;
                     end else begin
                        st_q   <= S_IDLE;
                        done_q <= 1'b1;
                     end
                  end else begin
                     bit_q   <= bit_q + 1'b1;
                     di_q    <= shreg_q[FRAME_W-1];
                     shreg_q <= shreg_q << 1;
                  end
               end
            end
            S_POLL: if (poll_rdy) begin
               done_q <= 1'b1;
               st_q   <= S_IDLE;
            end else if (poll_to) begin
               to_q <= 1'b1;
               st_q <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign busy    = (st_q != S_IDLE);
   assign done    = done_q;
   assign timeout = to_q;
   assign rdata   = rd_q;
   assign ee_cs   = scs_q | poll_cs;
   assign ee_sk   = sk_q;
   assign ee_di   = di_q;

   // Checker-side count of cycles with chip select low.
   logic [GW-1:0] cs_low_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_low_cnt <= '0;
      end else if (ee_cs) begin
         cs_low_cnt <= '0;
      end else if (cs_low_cnt != GW'(CS_LOW_CYC)) begin
         cs_low_cnt <= cs_low_cnt + 1'b1;
      end
   end

   AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sk |-> ee_cs); // R6
   AST_DI_HOLD_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sk |-> $stable(ee_di)); // R6
   AST_CS_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ee_cs) && st_q == S_POLL) |-> (cs_low_cnt >= GW'(CS_LOW_CYC))); // R7
   AST_POLL_IN_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      poll_act |-> (st_q == S_POLL)); // R7
   AST_END_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (done || timeout) |-> ($past(busy) && !busy)); // R9
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != S_SHIFT || !read_q) |=> $stable(rdata)); // R11

endmodule

// File: tb/seeprom_cmd_master_tb.sv
module seeprom_cmd_master_tb;

   localparam int SKH = 2;
   localparam int CSL = 4;
   localparam int STL = 4;
   localparam int TMO = 400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [5:0]  cmd_addr = 6'd0;
   logic [15:0] cmd_wdata = 16'd0;
   logic        busy, done, timeout, ee_cs, ee_sk, ee_di, ee_do;
   logic [15:0] rdata;

   always #4 clk = ~clk;

   seeprom_cmd_master #(
      .ADDR_W(6), .DATA_W(16), .SK_HALF(SKH),
      .CS_LOW_CYC(CSL), .SETTLE_CYC(STL), .TIMEOUT_CYC(TMO)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
      .timeout(timeout), .rdata(rdata), .ee_cs(ee_cs), .ee_sk(ee_sk),
      .ee_di(ee_di), .ee_do(ee_do)
   );

   int nchecks = 0;
   int nerr = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      nchecks++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- behavioural memory model ----------------
   int          cyc = 0;
   int          busy_len = 30;
   int          busy_end = 0;
   int          nbits = 0;
   int          frames = 0;
   logic [24:0] shreg = '0;
   logic [8:0]  cur_hdr = '0;
   logic [8:0]  last_hdr = '0;
   int          last_nbits = 0;
   logic [15:0] last_data = '0;
   logic [15:0] dout_word = '0;
   logic        reading = 1'b0;
   logic        status_mode = 1'b0;
   logic        wen = 1'b0;
   logic        mem_init = 1'b0;
   logic        do_bit = 1'b0;
   logic [15:0] mem [64];

   always @(posedge clk) cyc++;

   always @(posedge ee_sk or negedge ee_cs) begin
      if (!mem_init) begin
         for (int i = 0; i < 64; i++) mem[i] = 16'h1000 + 16'(i);
         mem_init = 1'b1;
      end
      if (!ee_cs) begin
         if (nbits > 0) begin
            frames++;
            last_hdr   = cur_hdr;
            last_nbits = nbits;
            last_data  = shreg[15:0];
            if (cur_hdr[8] && nbits >= 9) begin
               case (cur_hdr[7:6])
                  2'b01: if (nbits == 25) begin
                     if (wen) mem[cur_hdr[5:0]] = shreg[15:0];
                     status_mode = 1'b1; busy_end = cyc + (wen ? busy_len : 0);
                  end
                  2'b11: begin
                     if (wen) mem[cur_hdr[5:0]] = 16'hFFFF;
                     status_mode = 1'b1; busy_end = cyc + (wen ? busy_len : 0);
                  end
                  2'b00: case (cur_hdr[5:4])
                     2'b11: wen = 1'b1;
                     2'b00: wen = 1'b0;
                     2'b01: if (nbits == 25) begin
                        if (wen) for (int i = 0; i < 64; i++) mem[i] = shreg[15:0];
                        status_mode = 1'b1; busy_end = cyc + (wen ? busy_len : 0);
                     end
                     default: begin
                        if (wen) for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
                        status_mode = 1'b1; busy_end = cyc + (wen ? busy_len : 0);
                     end
                  endcase
                  default: ;
               endcase
            end
         end
         nbits   = 0;
         reading = 1'b0;
      end else begin
         shreg = {shreg[23:0], ee_di};
         nbits++;
         if (nbits == 1) status_mode = 1'b0;
         if (nbits == 9) begin
            cur_hdr = shreg[8:0];
            if (shreg[8:6] == 3'b110) begin
               dout_word = mem[shreg[5:0]];
               reading   = 1'b1;
            end
         end
      end
   end

   always @(negedge ee_sk) begin
      if (reading && nbits >= 9 && nbits <= 24) do_bit = dout_word[24 - nbits];
      else do_bit = 1'b0;
   end

   assign ee_do = status_mode ? (cyc >= busy_end) : do_bit;

   // ---------------- pin monitors ----------------
   logic prev_sk = 1'b0, prev_di = 1'b0, prev_cs = 1'b0, prev_busy = 1'b0;
   int   pin_bad = 0;
   int   lowrun = 0;
   int   min_gap = 1000;
   int   poll_rises = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (ee_sk && !ee_cs) pin_bad++;
         if (ee_sk && ee_di != prev_di) pin_bad++;
         if (ee_cs && !prev_cs && prev_busy) begin
            poll_rises++;
            if (lowrun < min_gap) min_gap = lowrun;
         end
         if (ee_cs) lowrun = 0; else lowrun++;
      end
      prev_sk = ee_sk; prev_di = ee_di; prev_cs = ee_cs; prev_busy = busy;
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      if (cyc > 150000) begin
         nerr++;
         nchecks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", nerr, nchecks);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   logic        got_done, got_to, saw_busy;
   logic [15:0] got_rd;
   int          op_cycles, poll_delta, pr0;

   task automatic start_cmd(input logic [2:0] op, input logic [5:0] a,
                            input logic [15:0] d);
      @(negedge clk);
      cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
      pr0 = poll_rises;
      @(negedge clk);
      cmd_valid = 1'b0;
      saw_busy = busy;
   endtask

   task automatic wait_end();
      int n = 1;
      while (!(done || timeout) && n < 4000) begin
         @(negedge clk);
         n++;
      end
      got_done = done; got_to = timeout; got_rd = rdata;
      op_cycles = n; poll_delta = poll_rises - pr0;
      chk(n < 4000, "R9 command end seen", 32'(n), 32'(4000));
   endtask

   task automatic run_cmd(input logic [2:0] op, input logic [5:0] a,
                          input logic [15:0] d);
      start_cmd(op, a, d);
      wait_end();
   endtask

   function automatic logic [15:0] pat(input int a);
      return 16'(a * 16'h0403) ^ 16'h5A3C;
   endfunction

   int f0;

   initial begin
      repeat (3) @(negedge clk);
      chk(ee_cs == 0 && ee_sk == 0 && ee_di == 0, "R1 pins in reset",
          {ee_cs, ee_sk, ee_di}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && done == 0 && timeout == 0, "R1 status after reset",
          {busy, done, timeout}, 0);
      chk(rdata == 16'h0, "R1 rdata after reset", rdata, 0);

      // write enable: extended opcode, sub-code 11, short frame, no poll
      run_cmd(3'd5, 6'h2A, 16'h0);
      chk(saw_busy == 1, "R9 busy after accept", saw_busy, 1);
      chk(last_hdr == 9'b1_00_11_0000, "R3 write-enable header", last_hdr, 9'b1_00_11_0000);
      chk(last_nbits == 9, "R4 write-enable length", last_nbits, 9);
      chk(got_done && !got_to && poll_delta == 0, "R10 write-enable no poll",
          {got_done, got_to, 4'(poll_delta)}, 6'b10_0000);
      chk(op_cycles <= 9 * 2 * SKH + 2, "R10 write-enable duration", op_cycles, 9 * 2 * SKH + 2);

      // write sweep over every address
      for (int a = 0; a < 64; a++) begin
         run_cmd(3'd1, 6'(a), pat(a));
         chk(last_hdr == {3'b101, 6'(a)} && last_nbits == 25, "R2 write header",
             {last_hdr, 8'(last_nbits)}, {3'b101, 6'(a), 8'd25});
         chk(last_data == pat(a), "R4 write data bits", last_data, pat(a));
         chk(got_done && !got_to && poll_delta == 1, "R7 write ready poll",
             {got_done, got_to, 4'(poll_delta)}, 6'b10_0001);
      end

      // read sweep
      for (int a = 0; a < 64; a++) begin
         run_cmd(3'd0, 6'(a), 16'hFFFF);
         chk(last_hdr == {3'b110, 6'(a)} && last_nbits == 25, "R2 read header",
             {last_hdr, 8'(last_nbits)}, {3'b110, 6'(a), 8'd25});
         chk(last_data == 16'h0, "R5 di low in read data phase", last_data, 0);
         chk(got_rd == pat(a), "R5 read word", got_rd, pat(a));
         chk(got_done && poll_delta == 0, "R10 read no poll",
             {got_done, 4'(poll_delta)}, 5'b1_0000);
      end

      // erase one word
      run_cmd(3'd2, 6'd10, 16'h0);
      chk(last_hdr == {3'b111, 6'd10} && last_nbits == 9, "R2 erase header",
          {last_hdr, 8'(last_nbits)}, {3'b111, 6'd10, 8'd9});
      chk(got_done && poll_delta == 1, "R7 erase poll", {got_done, 4'(poll_delta)}, 5'b1_0001);
      run_cmd(3'd0, 6'd10, 16'h0);
      chk(got_rd == 16'hFFFF, "R2 erased word", got_rd, 16'hFFFF);
      run_cmd(3'd0, 6'd11, 16'h0);
      chk(got_rd == pat(11), "R2 erase neighbour kept", got_rd, pat(11));

      // write-all
      run_cmd(3'd3, 6'h15, 16'hBEEF);
      chk(last_hdr == 9'b1_00_01_0000 && last_nbits == 25, "R3 write-all header",
          {last_hdr, 8'(last_nbits)}, {9'b1_00_01_0000, 8'd25});
      chk(last_data == 16'hBEEF, "R4 write-all data", last_data, 16'hBEEF);
      run_cmd(3'd0, 6'd0, 16'h0);
      chk(got_rd == 16'hBEEF, "R3 write-all word 0", got_rd, 16'hBEEF);
      run_cmd(3'd0, 6'd63, 16'h0);
      chk(got_rd == 16'hBEEF, "R3 write-all word 63", got_rd, 16'hBEEF);

      // erase-all
      run_cmd(3'd4, 6'h3F, 16'h0);
      chk(last_hdr == 9'b1_00_10_0000 && last_nbits == 9, "R3 erase-all header",
          {last_hdr, 8'(last_nbits)}, {9'b1_00_10_0000, 8'd9});
      run_cmd(3'd0, 6'd33, 16'h0);
      chk(got_rd == 16'hFFFF, "R3 erase-all word", got_rd, 16'hFFFF);

      // write disable; rdata must keep the last read word
      run_cmd(3'd6, 6'h3F, 16'h0);
      chk(last_hdr == 9'b1_00_00_0000 && last_nbits == 9, "R3 write-disable header",
          {last_hdr, 8'(last_nbits)}, {9'b1_00_00_0000, 8'd9});
      chk(got_done && poll_delta == 0, "R10 write-disable no poll",
          {got_done, 4'(poll_delta)}, 5'b1_0000);
      chk(rdata == 16'hFFFF, "R11 rdata held across non-read", rdata, 16'hFFFF);

      // command offered while busy is ignored
      run_cmd(3'd5, 6'd0, 16'h0);
      f0 = frames;
      start_cmd(3'd1, 6'd7, 16'h1234);
      repeat (10) @(negedge clk);
      cmd_op = 3'd3; cmd_wdata = 16'h0000; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_end();
      repeat (4) @(negedge clk);
      chk(frames - f0 == 1, "R9 no frame for busy request", frames - f0, 1);
      run_cmd(3'd0, 6'd7, 16'h0);
      chk(got_rd == 16'h1234, "R9 target word", got_rd, 16'h1234);
      run_cmd(3'd0, 6'd8, 16'h0);
      chk(got_rd == 16'hFFFF, "R9 other word untouched", got_rd, 16'hFFFF);

      // unused op code
      f0 = frames;
      @(negedge clk);
      cmd_op = 3'd7; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (10) @(negedge clk);
      chk(busy == 0 && ee_cs == 0 && frames == f0, "R9 op 7 ignored",
          {busy, ee_cs, 8'(frames - f0)}, 0);

      // memory never ready
      busy_len = 1000;
      run_cmd(3'd1, 6'd2, 16'hCAFE);
      chk(got_to && !got_done, "R8 timeout pulse", {got_to, got_done}, 2'b10);
      @(negedge clk);
      chk(busy == 0 && timeout == 0 && ee_cs == 0, "R8 idle after timeout",
          {busy, timeout, ee_cs}, 0);
      chk(op_cycles >= TMO, "R8 waited full limit", op_cycles, TMO);
      chk(rdata == 16'hFFFF, "R11 rdata held after timeout", rdata, 16'hFFFF);
      repeat (1100) @(negedge clk);
      busy_len = 30;

      chk(pin_bad == 0, "R6 clock and data ordering", pin_bad, 0);
      chk(poll_rises > 0 && min_gap >= CSL, "R7 chip select low gap", min_gap, CSL);

      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
   end

endmodule